// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block holds the static settings of an analog storage-interface PHY in a small bank of 32-bit registers. It sits on a single-cycle memory-mapped port made of valid, write, byte address and data signals. Each register keeps 16 bits of state. Every write word carries its own enable mask in its upper half, so software can change one field without first reading the register back.

Two registers have fields wired to the PHY pins. Register 6 holds the power-up (active-high power-down-bar) bit, the DLL enable and a 3-bit drive-strength code. Register 0 holds the output tap delay select, the tap delay enable and the DLL frequency band. A read-only status word reports two flags from the analog side, calibration finished and DLL locked. Both flags pass through a synchronizer before software can read them.

Top module: `phyctl_regbank`

## Requirements
- R1: After a synchronous reset, every control register reads 0x00000000. All PHY outputs are low: the PHY is powered down, the DLL is off, and the drive code, tap select, tap enable and frequency band are all zero.
- R2: On an accepted write, stored bit x (0..15) takes data bit x only when bit x+16 of the write word is 1. Every other stored bit keeps its value.
- R3: Control registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. A read of one of them returns the 16 stored bits in bits 15:0, with bits 31:16 read as zero.
- R4: Register 6 (offset 0x18) drives the PHY power-up output from bit 0, the DLL enable from bit 1 and the drive-strength code from bits 6:4. The codes are 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm. Each output changes on the clock edge that accepts the write.
- R5: Register 0 (offset 0x00) drives the tap delay select from bits 10:7, the tap delay enable from bit 11 and the frequency band from bits 13:12.
- R6: The status word at offset 0x20 reports DLL locked in bit 5 and calibration done in bit 6. All other bits read zero. Each flag passes through SYNC_STAGES flops before a read can return it.
- R7: A write to the status offset, to an unmapped offset (0x1C, 0x24 to 0x3C) or to an address that is not word aligned changes no register and no PHY output.
- R8: A read of an unmapped offset or of an address that is not word aligned returns zero.
- R9: Read data and the read-valid strobe are registered. Read-valid is high for exactly the one cycle after an accepted read and stays low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Transfer request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write word: mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| ana_cal_done | input | 1 | Calibration finished flag from the analog side (asynchronous) |
| ana_dll_lock | input | 1 | DLL locked flag from the analog side (asynchronous) |
| phy_pwr_on | output | 1 | Power-up control (power-down-bar) |
| phy_dll_en | output | 1 | DLL enable |
| phy_drive_code | output | 3 | Drive-strength code |
| phy_tap_sel | output | 4 | Output tap delay select |
| phy_tap_en | output | 1 | Output tap delay enable |
| phy_freq_sel | output | 2 | DLL frequency band |

## Verification
A write takes effect on the edge that accepts it. The PHY outputs therefore show the new value half a cycle later, and the bench samples them on the falling edge that follows the accepting edge. Read data and read-valid come one edge after the read is accepted, and each read is checked on the next falling edge. The status flags need SYNC_STAGES edges before they are visible, plus one edge for the read. The bench holds each flag pattern for several cycles longer than that before it reads the status word.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
  localparam int WORD_W     = 32;
  localparam int HALF_W     = 16;
  localparam int NUM_CTRL   = 7;
  localparam int STATUS_IDX = 8;

  // register 6 fields
  localparam int PWR_REG     = 6;
  localparam int PWR_BIT     = 0;
  localparam int DLLEN_BIT   = 1;
  localparam int DRV_LSB     = 4;
  localparam int DRV_W       = 3;

  // register 0 fields
  localparam int TIMING_REG  = 0;
  localparam int TAPSEL_LSB  = 7;
  localparam int TAPSEL_W    = 4;
  localparam int TAPEN_BIT   = 11;
  localparam int FREQ_LSB    = 12;
  localparam int FREQ_W      = 2;

  // status bits
  localparam int ST_LOCK_BIT = 5;
  localparam int ST_CAL_BIT  = 6;

  typedef enum logic [DRV_W-1:0] {
    DRV_50R  = 3'd0,
    DRV_33R  = 3'd1,
    DRV_66R  = 3'd2,
    DRV_100R = 3'd3,
    DRV_40R  = 3'd4
  } drive_code_e;
endpackage

// File: rtl/phyctl_wmask_reg.sv
module phyctl_wmask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (we)
      q <= (q & ~wmask) | (wdata & wmask);
  end

  // R2: bits outside the mask never move on a write
  a_r2_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> (((q ^ $past(q)) & ~$past(wmask)) == '0));

  // R2: masked bits land on the written data
  a_r2_masked_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> (((q ^ $past(wdata)) & $past(wmask)) == '0));

  // R7: no write enable, no change
  a_r7_hold_without_we: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we)) |-> $stable(q));
endmodule

// File: rtl/phyctl_status_sync.sv
module phyctl_status_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/phyctl_read_port.sv
module phyctl_read_port
  import phyctl_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               rd_en,
  input  logic                               rd_ctrl_hit,
  input  logic                               rd_status_hit,
  input  logic [IDX_W-1:0]                   rd_idx,
  input  logic [NUM_CTRL-1:0][HALF_W-1:0]    ctrl_q,
  input  logic [HALF_W-1:0]                  status_word,
  output logic [WORD_W-1:0]                  rdata,
  output logic                               rvalid
);
  logic [HALF_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    if (rd_status_hit)
      sel_word = status_word;
    else if (rd_ctrl_hit)
      for (int i = 0; i < NUM_CTRL; i++)
        if (int'(rd_idx) == i) sel_word = ctrl_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= {{(WORD_W-HALF_W){1'b0}}, sel_word};
    end
  end

  // R9: read-valid follows an accepted read by one cycle only
  a_r9_rvalid_timing: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rvalid == $past(rd_en)));

  // R3: upper half of a read is always zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[WORD_W-1:HALF_W] == '0));

  // R8: misses return zero
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && !$past(rd_ctrl_hit) && !$past(rd_status_hit))
      |-> (rdata == '0));

  // R6: only the two flag bits may be set in a status read
  a_r6_status_clean: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(rd_status_hit))
      |-> ((rdata & ~((WORD_W'(1) << ST_LOCK_BIT) | (WORD_W'(1) << ST_CAL_BIT))) == '0));
endmodule

// File: rtl/phyctl_regbank.sv
module phyctl_regbank
  import phyctl_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic                ana_cal_done,
  input  logic                ana_dll_lock,
  output logic                phy_pwr_on,
  output logic                phy_dll_en,
  output logic [DRV_W-1:0]    phy_drive_code,
  output logic [TAPSEL_W-1:0] phy_tap_sel,
  output logic                phy_tap_en,
  output logic [FREQ_W-1:0]   phy_freq_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             ctrl_hit;
  logic             status_hit;
  logic             wr_acc;
  logic             rd_acc;
  logic [NUM_CTRL-1:0]             ctrl_we;
  logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q;
  logic [1:0]                      flags_sync;
  logic [HALF_W-1:0]               status_word;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign ctrl_hit   = aligned && (int'(idx) < NUM_CTRL);
  assign status_hit = aligned && (int'(idx) == STATUS_IDX);
  assign wr_acc     = bus_valid && bus_write;
  assign rd_acc     = bus_valid && !bus_write;

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      assign ctrl_we[i] = wr_acc && ctrl_hit && (int'(idx) == i);

      phyctl_wmask_reg #(.W(HALF_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we[i]),
        .wdata (bus_wdata[HALF_W-1:0]),
        .wmask (bus_wdata[WORD_W-1:HALF_W]),
        .q     (ctrl_q[i])
      );
    end
  endgenerate

  phyctl_status_sync #(.STAGES(SYNC_STAGES), .N(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ana_cal_done, ana_dll_lock}),
    .sync_out (flags_sync)
  );

  always_comb begin
    status_word              = '0;
    status_word[ST_LOCK_BIT] = flags_sync[0];
    status_word[ST_CAL_BIT]  = flags_sync[1];
  end

  phyctl_read_port #(.IDX_W(IDX_W)) u_rd (
    .clk           (clk),
    .rst           (rst),
    .rd_en         (rd_acc),
    .rd_ctrl_hit   (ctrl_hit),
    .rd_status_hit (status_hit),
    .rd_idx        (idx),
    .ctrl_q        (ctrl_q),
    .status_word   (status_word),
    .rdata         (bus_rdata),
    .rvalid        (bus_rvalid)
  );

  assign phy_pwr_on     = ctrl_q[PWR_REG][PWR_BIT];
  assign phy_dll_en     = ctrl_q[PWR_REG][DLLEN_BIT];
  assign phy_drive_code = ctrl_q[PWR_REG][DRV_LSB +: DRV_W];
  assign phy_tap_sel    = ctrl_q[TIMING_REG][TAPSEL_LSB +: TAPSEL_W];
  assign phy_tap_en     = ctrl_q[TIMING_REG][TAPEN_BIT];
  assign phy_freq_sel   = ctrl_q[TIMING_REG][FREQ_LSB +: FREQ_W];

  // R7: at most one register is written per transfer
  a_r7_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_we));

  // R1: leaving reset, the PHY is powered down with the DLL off
  a_r1_reset_outputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!phy_pwr_on && !phy_dll_en && phy_drive_code == '0
                    && phy_tap_sel == '0 && !phy_tap_en && phy_freq_sel == '0));

  // R7: a write that misses every register leaves the PHY controls stable
  a_r7_miss_no_effect: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_acc) && !$past(ctrl_hit))
      |-> ($stable(phy_pwr_on) && $stable(phy_dll_en) && $stable(phy_drive_code)
           && $stable(phy_tap_sel) && $stable(phy_tap_en) && $stable(phy_freq_sel)));
endmodule

// File: tb/phyctl_regbank_test.sv
module phyctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        ana_cal_done = 1'b0;
  logic        ana_dll_lock = 1'b0;
  logic        phy_pwr_on, phy_dll_en, phy_tap_en;
  logic [2:0]  phy_drive_code;
  logic [3:0]  phy_tap_sel;
  logic [1:0]  phy_freq_sel;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  phyctl_regbank uut (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ana_cal_done(ana_cal_done), .ana_dll_lock(ana_dll_lock),
    .phy_pwr_on(phy_pwr_on), .phy_dll_en(phy_dll_en),
    .phy_drive_code(phy_drive_code), .phy_tap_sel(phy_tap_sel),
    .phy_tap_en(phy_tap_en), .phy_freq_sel(phy_freq_sel)
  );

  // mask/data walk on several registers: offset, write word, expected readback
  localparam int NV = 10;
  localparam logic [7:0]  V_OFF [NV] = '{8'h0C, 8'h0C, 8'h0C, 8'h0C, 8'h0C,
                                         8'h0C, 8'h0C, 8'h0C, 8'h14, 8'h04};
  localparam logic [31:0] V_WR  [NV] = '{32'hFFFF_A5A5, 32'h00FF_0000, 32'hF000_FFFF,
                                         32'h0000_1234, 32'h0F0F_0000, 32'h8001_0001,
                                         32'hFFFF_0000, 32'h5555_FFFF, 32'h0FF0_ABCD,
                                         32'h00FF_3C5A};
  localparam logic [15:0] V_EXP [NV] = '{16'hA5A5, 16'hA500, 16'hF500, 16'hF500,
                                         16'hF000, 16'h7001, 16'h0000, 16'h5555,
                                         16'h0BC0, 16'h005A};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[5:0]; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[5:0];
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  function automatic logic [31:0] outs();
    return {19'd0, phy_freq_sel, phy_tap_en, phy_tap_sel, phy_drive_code, phy_dll_en, phy_pwr_on};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [31:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    chk("R1 outputs", outs(), 32'h0);
    for (int i = 0; i < 7; i++) begin
      rd(8'(i * 4), d, v);
      chk("R1 reg reset", d, 32'h0);
    end

    // R2 / R3: table walk
    for (int k = 0; k < NV; k++) begin
      wr(V_OFF[k], V_WR[k]);
      chk("R9 no rvalid after write", {31'd0, bus_rvalid}, 32'h0);
      rd(V_OFF[k], d, v);
      chk("R2 R3 masked readback", d, {16'h0, V_EXP[k]});
      chk("R9 rvalid after read", {31'd0, v}, 32'h1);
    end

    // R4: register 6 fields
    wr(8'h18, 32'hFFFF_0000);
    chk("R4 cleared", outs(), 32'h0);
    wr(8'h18, 32'h0073_0041);   // pwr on, dll off, drive 4 (40 ohm)
    chk("R4 pwr", {31'd0, phy_pwr_on}, 32'h1);
    chk("R4 dll", {31'd0, phy_dll_en}, 32'h0);
    chk("R4 drive 40R", {29'd0, phy_drive_code}, 32'h4);
    wr(8'h18, 32'h0002_0002);   // dll on, others kept
    chk("R4 dll on", {31'd0, phy_dll_en}, 32'h1);
    chk("R4 pwr kept", {31'd0, phy_pwr_on}, 32'h1);
    chk("R4 drive kept", {29'd0, phy_drive_code}, 32'h4);
    wr(8'h18, 32'h0070_0030);   // drive 3 (100 ohm)
    chk("R4 drive 100R", {29'd0, phy_drive_code}, 32'h3);

    // R5: register 0 fields
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h00, 32'h3F80_2A00);
    chk("R5 freq", {30'd0, phy_freq_sel}, 32'h2);
    chk("R5 tap en", {31'd0, phy_tap_en}, 32'h1);
    chk("R5 tap sel", {28'd0, phy_tap_sel}, 32'h4);
    wr(8'h00, 32'h0780_0380);   // tap sel 7, rest kept
    chk("R5 tap sel 7", {28'd0, phy_tap_sel}, 32'h7);
    chk("R5 freq kept", {30'd0, phy_freq_sel}, 32'h2);

    // R6: status word
    ana_cal_done = 1'b1; ana_dll_lock = 1'b0;
    repeat (5) @(negedge clk);
    rd(8'h20, d, v);
    chk("R6 cal only", d, 32'h0000_0040);
    ana_dll_lock = 1'b1;
    repeat (5) @(negedge clk);
    rd(8'h20, d, v);
    chk("R6 both", d, 32'h0000_0060);
    ana_cal_done = 1'b0;
    repeat (5) @(negedge clk);
    rd(8'h20, d, v);
    chk("R6 lock only", d, 32'h0000_0020);

    // R7: writes that must be ignored
    snap = outs();
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_0000);
    wr(8'h1A, 32'hFFFF_0000);
    chk("R7 outputs unchanged", outs(), snap);
    rd(8'h00, d, v);
    chk("R7 reg0 unchanged", d, 32'h0000_2B80);
    rd(8'h18, d, v);
    chk("R7 reg6 unchanged", d, 32'h0000_0033);
    rd(8'h0C, d, v);
    chk("R7 reg3 unchanged", d, 32'h0000_5555);

    // R8: unmapped and misaligned reads
    rd(8'h1C, d, v);
    chk("R8 0x1C", d, 32'h0);
    chk("R9 rvalid on miss", {31'd0, v}, 32'h1);
    rd(8'h24, d, v);
    chk("R8 0x24", d, 32'h0);
    rd(8'h3C, d, v);
    chk("R8 0x3C", d, 32'h0);
    rd(8'h02, d, v);
    chk("R8 misaligned", d, 32'h0);

    // R9: strobe drops after one cycle
    @(negedge clk);
    chk("R9 rvalid single", {31'd0, bus_rvalid}, 32'h0);

    // R1: reset again clears everything
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 outputs after reset", outs(), 32'h0);
    rd(8'h0C, d, v);
    chk("R1 reg3 after reset", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule